// File: doc/BRIEF.md
# Quadrature Position Counter

The block turns the two phase signals of an incremental encoder into a position count. The two phase inputs arrive already filtered and are synchronized inside the block. A transition on either phase moves a 16-bit counter one step up or down, depending on how the two phases relate to each other after the transition. A 3-bit mode input selects which transitions are counted: those of phase A only, those of phase B only, or those of both. The last option gives four counts per encoder cycle.

The counter runs around a ring from zero to a programmable period value. Stepping up past the period returns it to zero, and stepping down from zero loads the period. Each such wrap raises a one-cycle pulse. A direction flag records the sense of the most recent counted step. Software is expected to set the period before it enables a counting mode. Mode codes outside 1 to 3 stop all counting.

Top module: `qenc_counter`

## Requirements
- R1: After a clock edge with `rst` high, `count` is 0, `dir_down` is 0 (up) and `wrap_pulse` is 0.
- R2: With `mode_sel` = 1, only transitions of phase A (`ch0_in`) step the counter and update `dir_down`. Transitions of phase B alone change neither.
- R3: With `mode_sel` = 2, only transitions of phase B (`ch1_in`) step the counter and update `dir_down`. Transitions of phase A alone change neither.
- R4: With `mode_sel` = 3, transitions of either phase step the counter, giving four steps per full encoder cycle.
- R5: A counted phase A transition steps up when the synchronized A and B levels differ after it, and steps down when they are equal.
- R6: A counted phase B transition steps up when the synchronized A and B levels are equal after it, and steps down when they differ.
- R7: `dir_down` becomes 0 on every counted up step and 1 on every counted down step. It holds its value while no step is counted.
- R8: An up step taken when `count` is at or above `period` loads 0.
- R9: A down step taken when `count` is 0 loads `period`.
- R10: `wrap_pulse` is high for exactly the cycle after a wrap of R8 or R9, and is low at all other times.
- R11: When both synchronized phases change in the same cycle, the event is discarded, whatever the mode: `count` and `dir_down` stay unchanged.
- R12: With `mode_sel` equal to 0 or to 4 through 7, no transition changes `count` or `dir_down`.
- R13: A level change on a phase input that is present at a rising edge shows on `count` after the third rising edge from that one. The first two edges pass it through the synchronizer and the third edge registers the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch0_in | input | 1 | Filtered phase A input |
| ch1_in | input | 1 | Filtered phase B input |
| mode_sel | input | 3 | Edge selection mode: 1 = A only, 2 = B only, 3 = both, other values = idle |
| period | input | 16 | Top of the counting ring |
| count | output | 16 | Current position |
| dir_down | output | 1 | 1 when the last counted step was downward |
| wrap_pulse | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
The hardest situations to reach from the ports are the discarded double transition and the wraps at both ends of the ring under every mode. A double transition needs both phases to flip in the same synchronizer sample, so the bench drives both pins at one clock edge in the middle of a run. It then resumes normal stepping, which shows that the count and the direction bit lost nothing and gained nothing. Wraps are reached by using a small period and walking the encoder repeatedly across zero in both senses. The bench also changes the input once per clock to press the edge detector, and it checks the exact three-edge latency with a single step into a quiet counter.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Mode codes that enable counting
    localparam logic [2:0] QM_ONLY_A = 3'd1;
    localparam logic [2:0] QM_ONLY_B = 3'd2;
    localparam logic [2:0] QM_BOTH   = 3'd3;

    // One synchronized sample of the two phases
    typedef struct packed {
        logic a;
        logic b;
    } qsample_t;

    // A decoded step request
    typedef struct packed {
        logic valid;
        logic up;
    } qstep_t;

    function automatic logic mode_takes_a(input logic [2:0] m);
        return (m == QM_ONLY_A) || (m == QM_BOTH);
    endfunction

    function automatic logic mode_takes_b(input logic [2:0] m);
        return (m == QM_ONLY_B) || (m == QM_BOTH);
    endfunction

    // Sense of a step, given the phase that moved and the levels after it
    function automatic logic step_is_up(input logic moved_a, input qsample_t now);
        if (moved_a)
            return now.a != now.b;
        else
            return now.a == now.b;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync
    import qenc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  qsample_t raw,
    output qsample_t synced
);
    localparam int NBITS = $bits(qsample_t);

    logic [NBITS-1:0] raw_bits;
    logic [NBITS-1:0] out_bits;

    assign raw_bits = raw;

    generate
        for (genvar i = 0; i < NBITS; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else if (STAGES == 1)
                    chain <= raw_bits[i];
                else
                    chain <= {chain[STAGES-2:0], raw_bits[i]};
            end
            assign out_bits[i] = chain[STAGES-1];
        end
    endgenerate

    assign synced = qsample_t'(out_bits);

endmodule

// File: rtl/qenc_edge_dir.sv
module qenc_edge_dir
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  qsample_t   cur,
    input  logic [2:0] mode,
    output qstep_t     step
);
    qsample_t prev_q;
    logic     moved_a;
    logic     moved_b;
    logic     clash;
    logic     take_a;
    logic     take_b;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= cur;
    end

    always_comb begin
        moved_a = cur.a != prev_q.a;
        moved_b = cur.b != prev_q.b;
        clash   = moved_a && moved_b;
        take_a  = moved_a && !clash && mode_takes_a(mode);
        take_b  = moved_b && !clash && mode_takes_b(mode);
        step.valid = take_a || take_b;
        if (take_a)
            step.up = step_is_up(1'b1, cur);
        else
            step.up = step_is_up(1'b0, cur);
    end

    // R11: a double transition never yields a step
    p_clash_dropped_r11: assert property (@(posedge clk) disable iff (rst)
        ((cur.a != prev_q.a) && (cur.b != prev_q.b)) |-> !step.valid);

    // R12: idle modes never yield a step
    p_idle_mode_r12: assert property (@(posedge clk) disable iff (rst)
        !(mode inside {3'd1, 3'd2, 3'd3}) |-> !step.valid);

    // R2: mode A-only ignores a lone B transition
    p_only_a_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && cur.a == prev_q.a) |-> !step.valid);

    // R3: mode B-only ignores a lone A transition
    p_only_b_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 && cur.b == prev_q.b) |-> !step.valid);

endmodule

// File: rtl/qenc_ring_counter.sv
module qenc_ring_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qstep_t           step,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_pulse
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             dir_q;
    logic             wrap_q;
    logic             wrap_d;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        if (step.valid) begin
            if (step.up) begin
                if (cnt_q >= period) begin
                    cnt_d  = ZERO;
                    wrap_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == ZERO) begin
                    cnt_d  = period;
                    wrap_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
            if (step.valid)
                dir_q <= !step.up;
        end
    end

    assign count      = cnt_q;
    assign dir_down   = dir_q;
    assign wrap_pulse = wrap_q;

    // R8: upward wrap to zero with a pulse
    p_up_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (step.valid && step.up && cnt_q >= period) |=> (cnt_q == ZERO && wrap_q));

    // R9: downward wrap to the period with a pulse
    p_down_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (step.valid && !step.up && cnt_q == ZERO) |=> (cnt_q == $past(period) && wrap_q));

    // R7: direction holds without a step
    p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !step.valid |=> $stable(dir_q));

    // R10: no pulse without a step in the previous cycle
    p_pulse_needs_step_r10: assert property (@(posedge clk) disable iff (rst)
        !step.valid |=> (!wrap_q && $stable(cnt_q)));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch0_in,
    input  logic             ch1_in,
    input  logic [2:0]       mode_sel,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_pulse
);
    qsample_t raw_s;
    qsample_t sync_s;
    qstep_t   step_s;

    assign raw_s.a = ch0_in;
    assign raw_s.b = ch1_in;

    qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_s),
        .synced (sync_s)
    );

    qenc_edge_dir u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (sync_s),
        .mode (mode_sel),
        .step (step_s)
    );

    qenc_ring_counter #(.CNT_W(CNT_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .step       (step_s),
        .period     (period),
        .count      (count),
        .dir_down   (dir_down),
        .wrap_pulse (wrap_pulse)
    );

    // R1: outputs are cleared by reset
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && !dir_down && !wrap_pulse));

endmodule

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ch0_in = 1'b0;
    logic        ch1_in = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic [15:0] period = 16'd0;
    logic [15:0] count;
    logic        dir_down;
    logic        wrap_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    compare_on = 1'b0;
    string tag = "R1";
    int    pos = 0;

    always #5 clk = ~clk;

    qenc_counter u_qenc_counter (
        .clk(clk), .rst(rst), .ch0_in(ch0_in), .ch1_in(ch1_in),
        .mode_sel(mode_sel), .period(period),
        .count(count), .dir_down(dir_down), .wrap_pulse(wrap_pulse)
    );

    // Behavioural reference: the entry at index 2 is the newest input sample
    logic [1:0] hist[$];
    int         m_cnt = 0;
    bit         m_dir = 0;
    bit         m_wrap = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{2'b00, 2'b00, 2'b00};
            m_cnt = 0; m_dir = 0; m_wrap = 0;
        end else begin
            logic [1:0] now_s, old_s;
            bit ea, eb, ta, tb, up;
            now_s = hist[1];
            old_s = hist[0];
            ea = now_s[1] != old_s[1];
            eb = now_s[0] != old_s[0];
            m_wrap = 0;
            ta = ea && !(ea && eb) && (mode_sel == 3'd1 || mode_sel == 3'd3);
            tb = eb && !(ea && eb) && (mode_sel == 3'd2 || mode_sel == 3'd3);
            if (ta || tb) begin
                up = ta ? (now_s[1] != now_s[0]) : (now_s[1] == now_s[0]);
                m_dir = !up;
                if (up) begin
                    if (m_cnt >= int'(period)) begin m_cnt = 0; m_wrap = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = int'(period); m_wrap = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            void'(hist.pop_front());
            hist.push_back({ch0_in, ch1_in});
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check(tag, int'(count), m_cnt, "count");
            check(tag, int'(dir_down), int'(m_dir), "dir_down");
            check(tag, int'(wrap_pulse), int'(m_wrap), "wrap_pulse");
        end
    end

    function automatic logic [1:0] qstate(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // Called just after a falling edge
    task automatic move(input int d, input int gap);
        pos += d;
        {ch0_in, ch1_in} = qstate(pos);
        repeat (gap) @(negedge clk);
    endtask

    task automatic walk(input int n, input int d, input int gap);
        for (int i = 0; i < n; i++) move(d, gap);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(count), 0, "count after reset");
        check("R1", int'(dir_down), 0, "dir after reset");
        check("R1", int'(wrap_pulse), 0, "wrap after reset");
        compare_on = 1'b1;

        // R4, R5, R6, R8: all edges, small ring
        period = 16'd5; mode_sel = 3'd3;
        tag = "R4"; walk(13, 1, 4);
        tag = "R8"; walk(6, 1, 3);
        // R9 downward wraps, R7 direction reversal
        tag = "R9"; walk(15, -1, 4);
        tag = "R7"; walk(3, 1, 4); walk(2, -1, 4); settle();
        tag = "R10"; walk(20, 1, 2);

        // R2 phase A only
        mode_sel = 3'd1; tag = "R2"; walk(12, 1, 4); walk(9, -1, 4); settle();
        // R3 phase B only
        mode_sel = 3'd2; tag = "R3"; walk(12, -1, 4); walk(9, 1, 4); settle();

        // R12 idle modes
        tag = "R12";
        mode_sel = 3'd0; walk(6, 1, 4);
        mode_sel = 3'd5; walk(6, -1, 4);
        mode_sel = 3'd7; walk(5, 1, 4);
        mode_sel = 3'd4; walk(3, -1, 4); settle();

        // R11 simultaneous change, in each counting mode
        tag = "R11";
        for (int m = 1; m <= 3; m++) begin
            mode_sel = 3'(m);
            walk(2, 1, 4);
            pos += 2; {ch0_in, ch1_in} = qstate(pos);
            repeat (4) @(negedge clk);
            walk(3, 1, 4);
        end
        settle();

        // R5, R6 fast stepping at one change per clock, both senses
        mode_sel = 3'd3; tag = "R5"; walk(10, 1, 1);
        tag = "R6"; walk(14, -1, 1); settle();

        // R8, R9 with a zero-width ring
        period = 16'd0; tag = "R8"; walk(4, 1, 3);
        tag = "R9"; walk(4, -1, 3); settle();

        // R13 exact latency with a wide ring
        period = 16'd1000; tag = "R13";
        walk(3, 1, 4); settle();
        begin
            int c0;
            c0 = int'(count);
            move(1, 0);
            @(posedge clk); @(posedge clk); @(negedge clk);
            check("R13", int'(count), c0, "count before third edge");
            @(negedge clk);
            check("R13", int'(count), c0 + 1, "count after third edge");
        end
        settle();

        compare_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule